// File: doc/BRIEF.md
# PLL Lock Health Monitor

This block watches two asynchronous health inputs of a frequency synthesizer: its lock-detect output and a reference-clock-present indication. It filters both, turns each loss and recovery into a time-tagged event record, and drives a transmit-inhibit request. The inhibit is raised while lock or reference is missing, and after a relock it is held until lock has stayed up for a programmable settle time.

Every accepted loss of lock or loss of reference opens an episode. The episode is closed by the matching recovery event, which carries the measured episode length in clock cycles. Saturating counters hold lock losses, relocks and reference losses for a maintenance reader. Lock losses are also counted per observation window of timebase ticks. When that count reaches a threshold, a maintenance-class flag is set. It is reported below the protect class that the inhibit represents.

Top module: `pll_lock_monitor`

## Requirements
- R1: Each input passes through a two-flop synchronizer, and a new level is accepted only after the synchronized input has differed from the accepted level for `debounce_i + 1` consecutive cycles. Shorter pulses produce no event and no change in the inhibit.
- R2: An accepted loss of lock asserts `tx_inhibit_o` no later than its event. The event has type 0 (lock lost) and a duration of 0.
- R3: An accepted regain of lock emits an event of type 1. Its duration equals the number of cycles the accepted lock level was low, which is the low time of the raw input.
- R4: Episode durations saturate at 2^DUR_W-1 and never wrap.
- R5: `lock_loss_cnt_o` increments on every lock-lost event and `relock_cnt_o` on every lock-regained event. The first acquisition of lock or reference after reset is not an episode: it produces no event and no count.
- R6: An accepted loss of reference emits type 2 with duration 0, asserts `tx_inhibit_o` and increments `ref_loss_cnt_o`. Its recovery emits type 3 with the duration of the absence.
- R7: After an accepted relock, `tx_inhibit_o` stays high until lock has held for `settle_i` cycles. It therefore falls `settle_i - 1` cycles after the lock-regained event is visible.
- R8: `maint_flag_o` sets when lock losses in the current window of `win_ticks_i` ticks reach `loss_thresh_i`. At a window end it is kept only if the window just closed reached the threshold; otherwise it clears.
- R9: `fault_class_o` is 1 (protect) whenever `tx_inhibit_o` is high, 2 (maintenance) when the flag is set without inhibit, and 0 otherwise.
- R10: `evt_ts_o` is taken from a free-running cycle counter at the cycle the transition is accepted. Loss and regain timestamps of one episode differ by its duration.
- R11: When lock and reference events are accepted in the same cycle, the lock event is emitted first and the reference event one cycle later, with the same timestamp.
- R12: In reset, `tx_inhibit_o` is 1, `fault_class_o` is 1, `evt_valid_o` and `maint_flag_o` are 0, and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_det_i | input | 1 | Asynchronous synthesizer lock indication |
| ref_ok_i | input | 1 | Asynchronous reference-present indication |
| tick_i | input | 1 | Timebase tick for the instability window |
| debounce_i | input | DB_W | Extra cycles an input change must persist |
| settle_i | input | SET_W | Cycles of stable lock before the inhibit releases |
| win_ticks_i | input | WIN_W | Window length in ticks |
| loss_thresh_i | input | CNT_W | Lock losses per window that set the maintenance flag |
| tx_inhibit_o | output | 1 | Transmit-inhibit request |
| fault_class_o | output | 2 | 0 none, 1 protect, 2 maintenance |
| maint_flag_o | output | 1 | Lock-instability maintenance flag |
| evt_valid_o | output | 1 | One-cycle strobe for an event record |
| evt_type_o | output | 2 | 0 lock lost, 1 lock regained, 2 ref lost, 3 ref restored |
| evt_ts_o | output | TS_W | Timestamp of the record |
| evt_dur_o | output | DUR_W | Episode duration on recovery records, else 0 |
| lock_loss_cnt_o | output | CNT_W | Lock losses since reset |
| relock_cnt_o | output | CNT_W | Relocks since reset |
| ref_loss_cnt_o | output | CNT_W | Reference losses since reset |

## Verification
The assertions assume `debounce_i` is at least 1. With that, accepted transitions on one input are at least two cycles apart, and the single deferred slot for a reference event can never be overrun. They also assume that `loss_thresh_i` is at least 1 and that configuration inputs change only while no episode is open. The stimulus programs a debounce of 3 and holds the configuration steady through every episode. It lowers the threshold only right after it has closed a window with ticks, when the window count is zero.

// File: rtl/pll_mon_pkg.sv
package pll_mon_pkg;
  typedef enum logic [1:0] {
    EVT_LOCK_LOST = 2'd0,
    EVT_LOCK_BACK = 2'd1,
    EVT_REF_LOST  = 2'd2,
    EVT_REF_BACK  = 2'd3
  } evt_kind_e;

  typedef enum logic [1:0] {
    FC_NONE    = 2'd0,
    FC_PROTECT = 2'd1,
    FC_MAINT   = 2'd2
  } fault_class_e;

  localparam int unsigned NUM_CH  = 2;
  localparam int unsigned CH_LOCK = 0;
  localparam int unsigned CH_REF  = 1;
endpackage

// File: rtl/pll_mon_filter.sv
module pll_mon_filter #(
  parameter int unsigned DB_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            raw_i,
  input  logic [DB_W-1:0] hold_i,
  output logic            level_o
);
  logic [1:0]      sync_q;
  logic [DB_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      cnt_q   <= '0;
      level_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] != level_o) begin
        if (cnt_q == hold_i) begin
          level_o <= sync_q[1];
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  // R1
  level_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o != $past(level_o)) |-> (level_o == $past(sync_q[1])));
endmodule

// File: rtl/pll_mon_episode.sv
module pll_mon_episode #(
  parameter int unsigned DUR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             level_i,
  output logic             lost_o,
  output logic             back_o,
  output logic [DUR_W-1:0] dur_o
);
  logic             level_d_q;
  logic             armed_q;
  logic [DUR_W-1:0] out_cnt_q;
  logic             fall, rise;

  assign fall   = level_d_q & ~level_i;
  assign rise   = ~level_d_q & level_i;
  assign lost_o = fall & armed_q;
  assign back_o = rise & armed_q;
  assign dur_o  = out_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_d_q <= 1'b0;
      armed_q   <= 1'b0;
      out_cnt_q <= '0;
    end else begin
      level_d_q <= level_i;
      if (rise) armed_q <= 1'b1;
      if (fall) out_cnt_q <= {{(DUR_W-1){1'b0}}, 1'b1};
      else if (!level_i && out_cnt_q != '1) out_cnt_q <= out_cnt_q + 1'b1;
    end
  end

  // R4
  dur_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_i && !fall) |=> (out_cnt_q >= $past(out_cnt_q)));
endmodule

// File: rtl/pll_mon_window.sv
module pll_mon_window #(
  parameter int unsigned WIN_W = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             loss_i,
  input  logic [WIN_W-1:0] win_ticks_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             flag_o
);
  logic [WIN_W-1:0] tick_cnt_q;
  logic [CNT_W-1:0] loss_cnt_q, loss_next;
  logic [WIN_W:0]   tick_nx;
  logic             win_end;

  assign loss_next = loss_cnt_q + {{(CNT_W-1){1'b0}}, (loss_i && loss_cnt_q != '1)};
  assign tick_nx   = {1'b0, tick_cnt_q} + 1'b1;
  assign win_end   = tick_i && (tick_nx >= {1'b0, win_ticks_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_cnt_q <= '0;
      loss_cnt_q <= '0;
      flag_o     <= 1'b0;
    end else if (win_end) begin
      tick_cnt_q <= '0;
      loss_cnt_q <= '0;
      flag_o     <= (loss_next >= thresh_i);
    end else begin
      if (tick_i) tick_cnt_q <= tick_cnt_q + 1'b1;
      loss_cnt_q <= loss_next;
      if (loss_next >= thresh_i) flag_o <= 1'b1;
    end
  end

  // R8
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(tick_i));
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
  import pll_mon_pkg::*;
#(
  parameter int unsigned TS_W  = 32,
  parameter int unsigned DUR_W = 16,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DB_W  = 8,
  parameter int unsigned SET_W = 16,
  parameter int unsigned WIN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_det_i,
  input  logic             ref_ok_i,
  input  logic             tick_i,
  input  logic [DB_W-1:0]  debounce_i,
  input  logic [SET_W-1:0] settle_i,
  input  logic [WIN_W-1:0] win_ticks_i,
  input  logic [CNT_W-1:0] loss_thresh_i,
  output logic             tx_inhibit_o,
  output logic [1:0]       fault_class_o,
  output logic             maint_flag_o,
  output logic             evt_valid_o,
  output logic [1:0]       evt_type_o,
  output logic [TS_W-1:0]  evt_ts_o,
  output logic [DUR_W-1:0] evt_dur_o,
  output logic [CNT_W-1:0] lock_loss_cnt_o,
  output logic [CNT_W-1:0] relock_cnt_o,
  output logic [CNT_W-1:0] ref_loss_cnt_o
);
  logic [NUM_CH-1:0] raw, level, lost, back;
  logic [DUR_W-1:0]  dur [NUM_CH];

  assign raw = {ref_ok_i, lock_det_i};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pll_mon_filter #(.DB_W(DB_W)) u_flt (
      .clk_i, .rst_ni, .raw_i(raw[c]), .hold_i(debounce_i), .level_o(level[c])
    );
    pll_mon_episode #(.DUR_W(DUR_W)) u_ep (
      .clk_i, .rst_ni, .level_i(level[c]),
      .lost_o(lost[c]), .back_o(back[c]), .dur_o(dur[c])
    );
  end

  pll_mon_window #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_win (
    .clk_i, .rst_ni, .tick_i, .loss_i(lost[CH_LOCK]),
    .win_ticks_i, .thresh_i(loss_thresh_i), .flag_o(maint_flag_o)
  );

  // protection path
  logic [SET_W-1:0] settle_q;
  logic             lock_ok, ref_ok;
  assign lock_ok = level[CH_LOCK];
  assign ref_ok  = level[CH_REF];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  settle_q <= '0;
    else if (!lock_ok)            settle_q <= '0;
    else if (settle_q < settle_i) settle_q <= settle_q + 1'b1;
  end

  assign tx_inhibit_o  = !lock_ok || !ref_ok || (settle_q < settle_i);
  assign fault_class_o = tx_inhibit_o ? FC_PROTECT : (maint_flag_o ? FC_MAINT : FC_NONE);

  // statistics
  logic [TS_W-1:0]  ts_q;
  logic [CNT_W-1:0] loss_cnt_q, relock_cnt_q, ref_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q         <= '0;
      loss_cnt_q   <= '0;
      relock_cnt_q <= '0;
      ref_cnt_q    <= '0;
    end else begin
      ts_q <= ts_q + 1'b1;
      if (lost[CH_LOCK] && loss_cnt_q != '1)   loss_cnt_q   <= loss_cnt_q + 1'b1;
      if (back[CH_LOCK] && relock_cnt_q != '1) relock_cnt_q <= relock_cnt_q + 1'b1;
      if (lost[CH_REF] && ref_cnt_q != '1)     ref_cnt_q    <= ref_cnt_q + 1'b1;
    end
  end

  assign lock_loss_cnt_o = loss_cnt_q;
  assign relock_cnt_o    = relock_cnt_q;
  assign ref_loss_cnt_o  = ref_cnt_q;

  // event records: lock first, reference deferred one cycle on collision
  logic             lk_evt, rf_evt, pend_q, evt_valid_q;
  evt_kind_e        lk_type, rf_type, pend_type_q, evt_type_q;
  logic [DUR_W-1:0] lk_dur, rf_dur, pend_dur_q, evt_dur_q;
  logic [TS_W-1:0]  pend_ts_q, evt_ts_q;

  assign lk_evt  = lost[CH_LOCK] | back[CH_LOCK];
  assign rf_evt  = lost[CH_REF] | back[CH_REF];
  assign lk_type = lost[CH_LOCK] ? EVT_LOCK_LOST : EVT_LOCK_BACK;
  assign rf_type = lost[CH_REF] ? EVT_REF_LOST : EVT_REF_BACK;
  assign lk_dur  = lost[CH_LOCK] ? '0 : dur[CH_LOCK];
  assign rf_dur  = lost[CH_REF] ? '0 : dur[CH_REF];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_valid_q <= 1'b0;
      evt_type_q  <= EVT_LOCK_LOST;
      evt_ts_q    <= '0;
      evt_dur_q   <= '0;
      pend_q      <= 1'b0;
      pend_type_q <= EVT_LOCK_LOST;
      pend_ts_q   <= '0;
      pend_dur_q  <= '0;
    end else begin
      evt_valid_q <= lk_evt | pend_q | rf_evt;
      if (lk_evt) begin
        evt_type_q <= lk_type;
        evt_ts_q   <= ts_q;
        evt_dur_q  <= lk_dur;
      end else if (pend_q) begin
        evt_type_q <= pend_type_q;
        evt_ts_q   <= pend_ts_q;
        evt_dur_q  <= pend_dur_q;
      end else if (rf_evt) begin
        evt_type_q <= rf_type;
        evt_ts_q   <= ts_q;
        evt_dur_q  <= rf_dur;
      end
      if (rf_evt && (lk_evt || pend_q)) begin
        pend_q      <= 1'b1;
        pend_type_q <= rf_type;
        pend_ts_q   <= ts_q;
        pend_dur_q  <= rf_dur;
      end else if (!lk_evt) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign evt_valid_o = evt_valid_q;
  assign evt_type_o  = evt_type_q;
  assign evt_ts_o    = evt_ts_q;
  assign evt_dur_o   = evt_dur_q;

  // R2
  inhibit_on_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_type_o == EVT_LOCK_LOST) |-> tx_inhibit_o);

  // R7
  settle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_inhibit_o) |-> (lock_ok && $past(lock_ok)));

  // R5
  relock_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (relock_cnt_q != $past(relock_cnt_q)) |-> $past(back[CH_LOCK]));

  // R11
  no_overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !lk_evt) |-> !rf_evt);
endmodule

// File: tb/pll_lock_monitor_tb_top.sv
module pll_lock_monitor_tb_top;
  localparam int TS_W = 32, DUR_W = 6, CNT_W = 8, DB_W = 4, SET_W = 8, WIN_W = 8;
  localparam int SETTLE = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lock_det = 1'b0, ref_ok = 1'b0, tick = 1'b0;
  logic [DB_W-1:0]  debounce = 4'd3;
  logic [SET_W-1:0] settle = SETTLE[SET_W-1:0];
  logic [WIN_W-1:0] win_ticks = 8'd4;
  logic [CNT_W-1:0] thresh = 8'd200;
  logic tx_inh, maint, evt_valid;
  logic [1:0] fclass, evt_type;
  logic [TS_W-1:0] evt_ts;
  logic [DUR_W-1:0] evt_dur;
  logic [CNT_W-1:0] loss_cnt, relock_cnt, ref_cnt;

  always #4 clk = ~clk;

  pll_lock_monitor #(.TS_W(TS_W), .DUR_W(DUR_W), .CNT_W(CNT_W), .DB_W(DB_W),
                     .SET_W(SET_W), .WIN_W(WIN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lock_det_i(lock_det), .ref_ok_i(ref_ok),
    .tick_i(tick), .debounce_i(debounce), .settle_i(settle), .win_ticks_i(win_ticks),
    .loss_thresh_i(thresh), .tx_inhibit_o(tx_inh), .fault_class_o(fclass),
    .maint_flag_o(maint), .evt_valid_o(evt_valid), .evt_type_o(evt_type),
    .evt_ts_o(evt_ts), .evt_dur_o(evt_dur), .lock_loss_cnt_o(loss_cnt),
    .relock_cnt_o(relock_cnt), .ref_loss_cnt_o(ref_cnt)
  );

  int total = 0, bad = 0, cyc = 0, ev_n = 0, inh_fall_cyc = -1;
  int exp_loss = 0, exp_relock = 0;
  bit done = 1'b0, inh_prev = 1'b1;
  int ev_type [64];
  longint ev_ts [64];
  int ev_dur [64];
  int ev_cyc [64];
  bit ev_inh [64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (evt_valid && ev_n < 64) begin
      ev_type[ev_n] = int'(evt_type);
      ev_ts[ev_n]   = longint'(evt_ts);
      ev_dur[ev_n]  = int'(evt_dur);
      ev_cyc[ev_n]  = cyc;
      ev_inh[ev_n]  = tx_inh;
      ev_n++;
    end
    if (inh_prev && !tx_inh) inh_fall_cyc = cyc;
    inh_prev = tx_inh;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drop_lock(input int len);
    @(negedge clk) lock_det = 1'b0;
    wait_cyc(len);
    lock_det = 1'b1;
    wait_cyc(len + 40);
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
    wait_cyc(2);
  endtask

  task automatic t_reset;
    wait_cyc(3);
    chk("R12 inhibit", tx_inh, 1);
    chk("R12 fault_class", fclass, 1);
    chk("R12 evt_valid", evt_valid, 0);
    chk("R12 maint", maint, 0);
    chk("R12 counters", loss_cnt + relock_cnt + ref_cnt, 0);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_acquire;
    @(negedge clk) begin ref_ok = 1'b1; lock_det = 1'b1; end
    wait_cyc(40);
    chk("R5 no event on first acquisition", ev_n, 0);
    chk("R5 relock count on acquisition", relock_cnt, 0);
    chk("R7 inhibit released", tx_inh, 0);
    chk("R9 fault_class none", fclass, 0);
  endtask

  task automatic t_glitch;
    drop_lock(3);
    chk("R1 short glitch no event", ev_n, 0);
    chk("R1 short glitch loss count", loss_cnt, 0);
    chk("R1 short glitch inhibit", tx_inh, 0);
    chk("R1 short glitch inhibit never rose", inh_fall_cyc < 0 || inh_fall_cyc < 60, 1);
  endtask

  task automatic t_loss(input int len);
    int b = ev_n;
    int ed = (len > 63) ? 63 : len;
    drop_lock(len);
    exp_loss++; exp_relock++;
    chk("R2 R3 two events", ev_n - b, 2);
    chk("R2 lost type", ev_type[b], 0);
    chk("R2 lost dur", ev_dur[b], 0);
    chk("R2 inhibit at loss", ev_inh[b], 1);
    chk("R3 regain type", ev_type[b+1], 1);
    chk("R3 R4 regain dur", ev_dur[b+1], ed);
    chk("R10 ts delta", ev_ts[b+1] - ev_ts[b], len);
    chk("R7 settle release", inh_fall_cyc - ev_cyc[b+1], SETTLE - 1);
    chk("R5 loss count", loss_cnt, exp_loss);
    chk("R5 relock count", relock_cnt, exp_relock);
  endtask

  task automatic t_ref;
    int b = ev_n;
    @(negedge clk) ref_ok = 1'b0;
    wait_cyc(30);
    ref_ok = 1'b1;
    wait_cyc(40);
    chk("R6 two events", ev_n - b, 2);
    chk("R6 ref lost type", ev_type[b], 2);
    chk("R6 ref lost dur", ev_dur[b], 0);
    chk("R6 inhibit on ref loss", ev_inh[b], 1);
    chk("R6 ref back type", ev_type[b+1], 3);
    chk("R6 ref back dur", ev_dur[b+1], 30);
    chk("R6 ref loss count", ref_cnt, 1);
    chk("R6 inhibit released", tx_inh, 0);
  endtask

  task automatic t_both;
    int b = ev_n;
    @(negedge clk) begin lock_det = 1'b0; ref_ok = 1'b0; end
    wait_cyc(30);
    lock_det = 1'b1; ref_ok = 1'b1;
    wait_cyc(50);
    exp_loss++; exp_relock++;
    chk("R11 four events", ev_n - b, 4);
    chk("R11 lock lost first", ev_type[b], 0);
    chk("R11 ref lost second", ev_type[b+1], 2);
    chk("R11 one cycle apart", ev_cyc[b+1] - ev_cyc[b], 1);
    chk("R11 same ts on loss", ev_ts[b+1], ev_ts[b]);
    chk("R11 lock back first", ev_type[b+2], 1);
    chk("R11 ref back second", ev_type[b+3], 3);
    chk("R11 same ts on recovery", ev_ts[b+3], ev_ts[b+2]);
    chk("R11 ref dur", ev_dur[b+3], 30);
    chk("R6 ref loss count", ref_cnt, 2);
  endtask

  task automatic t_window;
    pulse_ticks(4);
    @(negedge clk) thresh = 8'd3;
    drop_lock(8);
    drop_lock(8);
    exp_loss += 2;
    chk("R8 below threshold", maint, 0);
    chk("R9 fault none below threshold", fclass, 0);
    drop_lock(8);
    exp_loss++;
    chk("R8 threshold reached", maint, 1);
    chk("R9 fault maintenance", fclass, 2);
    chk("R5 loss count window", loss_cnt, exp_loss);
    pulse_ticks(4);
    chk("R8 kept after busy window", maint, 1);
    pulse_ticks(4);
    chk("R8 cleared after quiet window", maint, 0);
    chk("R9 fault none after clear", fclass, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_acquire();
    inh_fall_cyc = -1;
    t_glitch();
    t_loss(4);
    t_loss(20);
    t_loss(100);
    t_ref();
    t_both();
    t_window();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule